// File: doc/BRIEF.md
# External Pin Interrupt Detector

The block watches a bank of external pins (eight by default) and turns selected pin activity into interrupt requests. Each pin has its own trigger condition: it fires while the pin is low, while the pin is high, on a low-to-high transition, or on a high-to-low transition. Every pin first passes through a two-stage synchroniser. When the chosen condition is seen, a sticky cause flag for that channel is set. Each channel also has an enable bit. A channel requests service only when both its flag and its enable bit are set. All channel requests are ORed into one interrupt line.

Software reaches three registers over a plain single-cycle register port. The trigger-select register holds two bits per channel. The cause-flag register can be read, and a flag is cleared by writing zero to its bit. The enable register holds one bit per channel. Reads are combinational. A write is taken on the clock edge where `bus_wr` is high. A service routine clears only the flag it handled, and it does this by writing ones to every other bit. This port carries register accesses, not a data stream, so it has no valid/ready handshake and no back-pressure.

Top module: `exti_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, the trigger-select, cause-flag and enable registers read zero, `irq_vec` is zero and `irq_o` is low.
- R2: Address 0 selects the trigger register, with channel c in bits 2c+1:2c. Address 2 selects the enable register, with channel c in bit c. Both read back what was written. Enable bits above the channel count read zero, and address 3 reads zero.
- R3: Trigger code 2'b10 sets a channel's flag on a rising pin transition and not on a falling one.
- R4: Trigger code 2'b11 sets a channel's flag on a falling pin transition and not on a rising one.
- R5: Trigger code 2'b01 sets the flag whenever the synchronised pin is high. The flag stays set after the pin goes low again.
- R6: Trigger code 2'b00 sets the flag whenever the synchronised pin is low. In either level mode, writing zero to the flag while the level is still present leaves it set.
- R7: A flag is set by its trigger condition even when its enable bit is 0. It then produces no request.
- R8: A write to address 1 clears each flag whose data bit is 0 and leaves each flag whose data bit is 1 unchanged. Flag bits are in channel order, with channel c in bit c. Flags never fall by any other means except reset.
- R9: When a trigger event and a clearing write reach the same flag on the same clock edge, the flag ends up set.
- R10: `irq_vec[c]` is high exactly when flag c and enable c are both set. `irq_o` is the OR of `irq_vec`.
- R11: A pin change that meets its trigger condition shows in the flag on the third rising clock edge after the change, and not on the second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | N | External pins, asynchronous to clk |
| bus_wr | input | 1 | Register write strobe, taken on the rising edge |
| bus_addr | input | 2 | Register address: 0 trigger, 1 flags, 2 enable |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for `bus_addr`, combinational |
| irq_vec | output | N | Per-channel request (flag AND enable) |
| irq_o | output | 1 | Aggregate interrupt request |

## Verification
The bench builds the block with N = 4 and DW = 8. At that size one byte holds the whole trigger register, and the bench can sweep every trigger code over every channel, in both pin directions, in a few hundred cycles. At each step it computes the expected flag vector and request vector from a small model of the four conditions. Directed sequences then place a clearing write on the exact edge where a trigger event lands. They also clear a flag while its level is held, and check the two-edge synchroniser delay by sampling one cycle before the flag should rise.

// File: rtl/exti_pkg.sv
package exti_pkg;

  // Two-bit trigger code per channel
  typedef enum logic [1:0] {
    TRIG_LOW  = 2'b00,
    TRIG_HIGH = 2'b01,
    TRIG_RISE = 2'b10,
    TRIG_FALL = 2'b11
  } trig_mode_e;

  // Register addresses
  localparam logic [1:0] ADDR_TRIG = 2'd0;
  localparam logic [1:0] ADDR_FLAG = 2'd1;
  localparam logic [1:0] ADDR_ENAB = 2'd2;

endpackage

// File: rtl/exti_sync.sv
module exti_sync #(
  parameter int   N       = 8,
  parameter logic RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] sync_o
);

  for (genvar c = 0; c < N; c++) begin : g_ch
    logic meta_q, stab_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= RST_VAL;
        stab_q <= RST_VAL;
      end else begin
        meta_q <= async_i[c];
        stab_q <= meta_q;
      end
    end
    assign sync_o[c] = stab_q;
  end

endmodule

// File: rtl/exti_detect.sv
module exti_detect
  import exti_pkg::*;
#(
  parameter int   N       = 8,
  parameter logic RST_VAL = 1'b1,
  localparam int  TW      = 2 * N
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  sync_i,
  input  logic [TW-1:0] mode_i,
  output logic [N-1:0]  set_o
);

  logic [N-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= {N{RST_VAL}};
    else        prev_q <= sync_i;
  end

  for (genvar c = 0; c < N; c++) begin : g_ch
    trig_mode_e mode;
    assign mode = trig_mode_e'(mode_i[2*c +: 2]);
    always_comb begin
      unique case (mode)
        TRIG_LOW:  set_o[c] = ~sync_i[c];
        TRIG_HIGH: set_o[c] =  sync_i[c];
        TRIG_RISE: set_o[c] =  sync_i[c] & ~prev_q[c];
        TRIG_FALL: set_o[c] = ~sync_i[c] &  prev_q[c];
        default:   set_o[c] = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/exti_regs.sv
module exti_regs
  import exti_pkg::*;
#(
  parameter int  N  = 8,
  parameter int  DW = 16,
  localparam int TW = 2 * N
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [N-1:0]  set_i,
  output logic [TW-1:0] mode_o,
  output logic [N-1:0]  flag_o,
  output logic [N-1:0]  enab_o
);

  logic [TW-1:0] mode_q;
  logic [N-1:0]  flag_q, enab_q, keep;
  logic          wr_trig, wr_flag, wr_enab;

  assign wr_trig = bus_wr && (bus_addr == ADDR_TRIG);
  assign wr_flag = bus_wr && (bus_addr == ADDR_FLAG);
  assign wr_enab = bus_wr && (bus_addr == ADDR_ENAB);

  // Zero bits of a flag write drop flags; new events override the drop.
  assign keep = wr_flag ? bus_wdata[N-1:0] : '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      flag_q <= '0;
      enab_q <= '0;
    end else begin
      if (wr_trig) mode_q <= bus_wdata[TW-1:0];
      if (wr_enab) enab_q <= bus_wdata[N-1:0];
      flag_q <= (flag_q & keep) | set_i;
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      ADDR_TRIG: bus_rdata[TW-1:0] = mode_q;
      ADDR_FLAG: bus_rdata[N-1:0]  = flag_q;
      ADDR_ENAB: bus_rdata[N-1:0]  = enab_q;
      default:   bus_rdata         = '0;
    endcase
  end

  assign mode_o = mode_q;
  assign flag_o = flag_q;
  assign enab_o = enab_q;

endmodule

// File: rtl/exti_ctrl.sv
module exti_ctrl #(
  parameter int   N        = 8,
  parameter int   DW       = 16,   // must be at least 2*N
  parameter logic PIN_IDLE = 1'b1  // synchroniser reset value
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  pin_i,
  input  logic          bus_wr,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic [N-1:0]  irq_vec,
  output logic          irq_o
);

  localparam int TW = 2 * N;

  logic [N-1:0]  pin_sync, set_vec, flag_q, enab_q;
  logic [TW-1:0] mode_q;

  exti_sync #(.N(N), .RST_VAL(PIN_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(pin_i), .sync_o(pin_sync)
  );

  exti_detect #(.N(N), .RST_VAL(PIN_IDLE)) u_detect (
    .clk(clk), .rst_n(rst_n), .sync_i(pin_sync), .mode_i(mode_q),
    .set_o(set_vec)
  );

  exti_regs #(.N(N), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .set_i(set_vec),
    .mode_o(mode_q), .flag_o(flag_q), .enab_o(enab_q)
  );

  assign irq_vec = flag_q & enab_q;
  assign irq_o   = |irq_vec;

endmodule

// File: rtl/exti_ctrl_chk.sv
module exti_ctrl_chk
  import exti_pkg::*;
#(
  parameter int N  = 8,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic [1:0]    bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic [N-1:0]  set_vec,
  input logic [N-1:0]  flag_q,
  input logic [N-1:0]  enab_q,
  input logic [N-1:0]  irq_vec,
  input logic          irq_o
);

  logic flag_wr;
  assign flag_wr = bus_wr && (bus_addr == ADDR_FLAG);

  // R1: quiet outputs while in reset
  always @(posedge clk)
    if (!rst_n) a_r1_reset_quiet: assert (irq_o == 1'b0 && flag_q == '0);

  // R8: a zero data bit without a concurrent event drops the flag
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    flag_wr |=> ((flag_q & $past(~bus_wdata[N-1:0] & ~set_vec)) == '0));

  // R8: flags do not fall without a flag write
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_wr |=> ((~flag_q & $past(flag_q)) == '0));

  // R9: every detected event leaves its flag set
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((flag_q & $past(set_vec)) == $past(set_vec)));

  // R10: requests only from enabled, flagged channels
  a_r10_gate: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_vec & ~(flag_q & enab_q)) == '0));

  a_r10_any: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (irq_vec != '0));

endmodule

bind exti_ctrl exti_ctrl_chk #(.N(N), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .set_vec(set_vec), .flag_q(flag_q),
  .enab_q(enab_q), .irq_vec(irq_vec), .irq_o(irq_o)
);

// File: tb/exti_ctrl_test.sv
module exti_ctrl_test;
  localparam int N  = 4;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  pins;
  logic          bus_wr;
  logic [1:0]    bus_addr;
  logic [DW-1:0] bus_wdata;
  wire  [DW-1:0] bus_rdata;
  wire  [N-1:0]  irq_vec;
  wire           irq_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  exti_ctrl #(.N(N), .DW(DW), .PIN_IDLE(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .pin_i(pins), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_vec(irq_vec), .irq_o(irq_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [DW-1:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  function automatic string mode_tag(input int m);
    case (m)
      0: return "R6";
      1: return "R5";
      2: return "R3";
      default: return "R4";
    endcase
  endfunction

  initial begin
    logic [DW-1:0] d;
    logic [N-1:0]  exp_f, en;
    pins = '1; rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    cyc(3);
    rd(2'd1, d); check("R1 flags in reset", d, 0);
    check("R1 irq in reset", {irq_vec, irq_o}, 0);
    rst_n = 1'b1;
    cyc(5);
    rd(2'd0, d); check("R1 trig after reset", d, 0);
    rd(2'd1, d); check("R1 flags after reset", d, 0);
    rd(2'd2, d); check("R1 enable after reset", d, 0);

    // R2 readback
    wr(2'd0, 8'hA5); rd(2'd0, d); check("R2 trig readback", d, 8'hA5);
    wr(2'd2, 8'hFF); rd(2'd2, d); check("R2 enable readback", d, 8'h0F);
    rd(2'd3, d); check("R2 unused address", d, 0);
    wr(2'd2, 8'h00);

    // Sweep every trigger code over every channel
    for (int m = 0; m < 4; m++) begin
      logic idle;
      idle = (m == 0 || m == 3);
      pins = {N{idle}};
      cyc(4);
      wr(2'd0, {N{m[1:0]}});
      cyc(4);
      wr(2'd1, '0);
      cyc(1);
      en = m[0] ? 4'b1011 : 4'b0101;
      wr(2'd2, DW'(en));
      exp_f = '0;
      rd(2'd1, d); check({mode_tag(m), " flags cleared"}, d, 0);
      for (int ch = 0; ch < N; ch++) begin
        for (int step = 0; step < 2; step++) begin
          logic p0, p1, ev;
          p0 = pins[ch]; p1 = ~p0;
          pins[ch] = p1;
          case (m)
            0: ev = !p1;
            1: ev = p1;
            2: ev = !p0 && p1;
            default: ev = p0 && !p1;
          endcase
          cyc(2);
          rd(2'd1, d); check("R11 flag not yet set", d, DW'(exp_f));
          exp_f = exp_f | (N'(ev) << ch);
          cyc(1);
          rd(2'd1, d); check({mode_tag(m), " flag after pin change"}, d, DW'(exp_f));
          check("R10 irq_vec", irq_vec, exp_f & en);
          check("R10 irq_o", irq_o, |(exp_f & en));
          if ((exp_f & ~en) != '0)
            check("R7 disabled flag gives no request", irq_vec & ~en, 0);
        end
      end
      wr(2'd1, 8'h06); rd(2'd1, d); check("R8 clear zero bits", d, 8'h06);
      wr(2'd1, 8'h06); rd(2'd1, d); check("R8 ones leave flags", d, 8'h06);
      wr(2'd1, 8'h00); rd(2'd1, d); check("R8 clear all", d, 0);
    end

    // R6: clearing while the level persists has no lasting effect
    wr(2'd2, 8'h00);
    pins = '0; cyc(4);
    wr(2'd0, 8'h55); cyc(4); wr(2'd1, 8'h00); cyc(1);
    pins[1] = 1'b1; cyc(4);
    rd(2'd1, d); check("R5 high level sets", d, 8'h02);
    wr(2'd1, 8'h00); cyc(1);
    rd(2'd1, d); check("R6 clear under held level", d, 8'h02);
    pins[1] = 1'b0; cyc(4); wr(2'd1, 8'h00); cyc(1);
    rd(2'd1, d); check("R6 clear after level gone", d, 0);

    // R9: event and clearing write on the same edge
    wr(2'd0, 8'hAA); cyc(4); wr(2'd1, 8'h00); cyc(1);
    pins[2] = 1'b1;
    cyc(2);
    wr(2'd1, 8'h00);
    rd(2'd1, d); check("R9 set wins over clear", d, 8'h04);

    // R7 / R10 enable gating
    check("R7 no request while disabled", {irq_vec, irq_o}, 0);
    wr(2'd2, 8'h04);
    check("R10 request when enabled", {irq_vec, irq_o}, {4'b0100, 1'b1});
    wr(2'd1, 8'hFB);
    check("R10 request drops after clear", {irq_vec, irq_o}, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule